// File: doc/BRIEF.md
# Hardware Thread Context Selector

This block decides which of a small set of hardware thread contexts drives the processor front end in each clock cycle. Every thread keeps its own architectural context elsewhere in the core, so a switch saves nothing. The selector only updates the thread number it presents and a matching one-hot grant. Both outputs come from registers.

Two scheduling modes are available. In coarse mode the owning thread keeps the front end until it reports a long-latency stall, and only then does ownership pass on. In fine mode ownership moves to the next eligible thread on every cycle, following a round-robin order that skips stalled and dormant threads.

The selector also holds an active or dormant flag for each thread. A software request for single-thread operation puts every thread except the current owner to sleep, so that thread receives every issue opportunity. A sleeping thread becomes active again on an external interrupt, on a timer (decrementer) interrupt, or on a wake instruction that names it.

Top module: `thread_ctx_sel`

## Requirements
- R1: After reset, thread 0 is the only active thread and the outputs are `grant`=0001, `tid`=0, `valid`=1.
- R2: In coarse mode (`fine_mode`=0), while the owning thread is active and its `stall` bit is low, `tid` and `grant` keep the same value. When its `stall` bit is high, the next eligible thread in increasing index order (wrapping) takes ownership on the following cycle.
- R3: In fine mode (`fine_mode`=1), on each cycle ownership moves to the first eligible thread after the current one in increasing index order, wrapping around. The current thread is taken again only if no other thread is eligible.
- R4: A thread is eligible only if it is active and its `stall` bit is low. Fine-mode rotation skips stalled threads.
- R5: A pulse on `single_req` leaves only the current owner (`tid`) active from the next cycle on. If a wake arrives in the same cycle, `single_req` takes priority over it.
- R6: A dormant thread is never granted. If exactly one thread is active and it is not stalled, that thread is granted on every cycle in both modes.
- R7: A dormant thread becomes active when its bit of `wake_ext` is high, when its bit of `wake_dec` is high, or when `wake_sw` is high and `wake_sw_id` equals its index.
- R8: When no thread is eligible, `grant` is all zeros, `valid` is 0 and `tid` holds its last value. When a thread becomes eligible again, it is granted on the next cycle.
- R9: `grant` is at most one-hot. When `valid` is 1, the bit of `grant` at position `tid` is the bit that is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fine_mode | input | 1 | 1 selects per-cycle rotation, 0 selects switching on stall |
| stall | input | NT | Long-latency stall flag for each thread |
| wake_ext | input | NT | External interrupt wake, one bit per thread |
| wake_dec | input | NT | Decrementer interrupt wake, one bit per thread |
| wake_sw | input | 1 | Wake instruction issued by the running thread |
| wake_sw_id | input | TW | Target thread of the wake instruction |
| single_req | input | 1 | Software request for single-thread operation |
| grant | output | NT | One-hot thread grant |
| tid | output | TW | Thread number of the owner |
| valid | output | 1 | A thread is granted this cycle |

## Verification
The bench wakes each sleeping thread through a different wake source, then uses fine-mode rotation to show that each one rejoined. A wake path that was wired wrong would leave a gap in the sequence. It holds a stall on a middle thread during rotation, and a selector that ignored stalls would grant that thread. It issues the single-thread request in the same cycle as a wake, and it stalls the only active thread. A design that let the wake win would grant the woken thread, and one that kept a stale grant would leave `valid` high with nothing eligible. In coarse mode it checks that the owner keeps the front end while it is not stalled and also after its stall clears, which catches a design that rotates without a stall.

// File: rtl/thread_ctx_sel.sv
module thread_ctx_sel #(
  parameter int NT = 4,
  parameter int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fine_mode,
  input  logic [NT-1:0] stall,
  input  logic [NT-1:0] wake_ext,
  input  logic [NT-1:0] wake_dec,
  input  logic          wake_sw,
  input  logic [TW-1:0] wake_sw_id,
  input  logic          single_req,
  output logic [NT-1:0] grant,
  output logic [TW-1:0] tid,
  output logic          valid
);

  logic [NT-1:0] act_q, act_nxt, wakes, elig, grant_q, grant_nxt;
  logic [TW-1:0] tid_q, tid_nxt, pick;
  logic          vld_q, vld_nxt, pick_ok, keep;

  assign wakes   = wake_ext | wake_dec | (wake_sw ? (NT'(1) << wake_sw_id) : '0);
  assign act_nxt = single_req ? (NT'(1) << tid_q) : (act_q | wakes);
  assign elig    = act_nxt & ~stall;

  always_comb begin
    pick_ok = 1'b0;
    pick    = tid_q;
    for (int k = 1; k <= NT; k++) begin
      int idx;
      idx = (int'(tid_q) + k) % NT;
      if (!pick_ok && elig[idx]) begin
        pick_ok = 1'b1;
        pick    = TW'(idx);
      end
    end
  end

  assign keep      = !fine_mode && vld_q && elig[tid_q];
  assign tid_nxt   = keep ? tid_q : pick;
  assign vld_nxt   = keep || pick_ok;
  assign grant_nxt = vld_nxt ? (NT'(1) << tid_nxt) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q   <= NT'(1);
      tid_q   <= '0;
      vld_q   <= 1'b1;
      grant_q <= NT'(1);
    end else begin
      act_q   <= act_nxt;
      tid_q   <= tid_nxt;
      vld_q   <= vld_nxt;
      grant_q <= grant_nxt;
    end
  end

  assign grant = grant_q;
  assign tid   = tid_q;
  assign valid = vld_q;

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_q) && (vld_q == (grant_q != '0)));

  assert_owner_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> grant_q[tid_q]);

  assert_no_dormant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q & ~act_q) == '0);

  assert_coarse_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fine_mode && vld_q && !stall[tid_q]) |=> (vld_q && $stable(tid_q)));

  assert_fine_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fine_mode && vld_q && !single_req && $countones(act_q & ~stall) >= 2)
      |=> (vld_q && !$stable(tid_q)));

  assert_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    single_req |=> $onehot(act_q));

endmodule

// File: tb/thread_ctx_sel_bench.sv
module thread_ctx_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fine_mode = 1'b0;
  logic [NT-1:0] stall = '0, wake_ext = '0, wake_dec = '0;
  logic          wake_sw = 1'b0;
  logic [TW-1:0] wake_sw_id = '0;
  logic          single_req = 1'b0;
  logic [NT-1:0] grant;
  logic [TW-1:0] tid;
  logic          valid;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thread_ctx_sel #(.NT(NT), .TW(TW)) u_thread_ctx_sel (
    .clk(clk), .rst_n(rst_n), .fine_mode(fine_mode), .stall(stall),
    .wake_ext(wake_ext), .wake_dec(wake_dec), .wake_sw(wake_sw),
    .wake_sw_id(wake_sw_id), .single_req(single_req),
    .grant(grant), .tid(tid), .valid(valid));

  task automatic expect_out(input logic v, input int t, input string req);
    logic [NT-1:0] eg;
    eg = v ? (NT'(1) << t) : '0;
    total++;
    if (valid !== v || grant !== eg || (v && tid !== TW'(t))) begin
      bad++;
      $display("FAIL %s: valid=%0b grant=%b tid=%0d expected valid=%0b grant=%b tid=%0d",
               req, valid, grant, tid, v, eg, t);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    step();
    expect_out(1, 0, "R1");
    rst_n = 1'b1;
    step();
    expect_out(1, 0, "R1");
  endtask

  task automatic t_wake_all();
    wake_ext = 4'b0010; wake_dec = 4'b0100; wake_sw = 1'b1; wake_sw_id = 2'd3;
    step();
    wake_ext = '0; wake_dec = '0; wake_sw = 1'b0;
    expect_out(1, 0, "R7");
  endtask

  task automatic t_coarse();
    for (int i = 0; i < 3; i++) begin step(); expect_out(1, 0, "R2"); end
    stall = 4'b0001;
    step(); expect_out(1, 1, "R2");
    step(); expect_out(1, 1, "R2");
    stall = '0;
    step(); expect_out(1, 1, "R2");
  endtask

  task automatic t_fine();
    fine_mode = 1'b1;
    step(); expect_out(1, 2, "R3");
    step(); expect_out(1, 3, "R3");
    step(); expect_out(1, 0, "R3");
    step(); expect_out(1, 1, "R7");
  endtask

  task automatic t_skip();
    stall = 4'b0100;
    step(); expect_out(1, 3, "R4");
    step(); expect_out(1, 0, "R4");
    step(); expect_out(1, 1, "R4");
    step(); expect_out(1, 3, "R4");
    stall = '0;
  endtask

  task automatic t_single();
    single_req = 1'b1; wake_ext = 4'b0010;
    step();
    single_req = 1'b0; wake_ext = '0;
    expect_out(1, 3, "R5");
    for (int i = 0; i < 3; i++) begin step(); expect_out(1, 3, "R6"); end
    fine_mode = 1'b0;
    step(); expect_out(1, 3, "R6");
    fine_mode = 1'b1;
  endtask

  task automatic t_idle();
    stall = 4'b1000;
    step(); expect_out(0, 3, "R8");
    total++;
    if (tid !== 2'd3) begin
      bad++;
      $display("FAIL R8: tid=%0d expected 3", tid);
    end
    step(); expect_out(0, 3, "R8");
    stall = '0;
    step(); expect_out(1, 3, "R8");
  endtask

  task automatic t_rewake();
    wake_ext = 4'b0001;
    step();
    wake_ext = '0;
    expect_out(1, 0, "R7");
    step(); expect_out(1, 3, "R6");
    step(); expect_out(1, 0, "R6");
  endtask

  initial begin
    t_reset();
    t_wake_all();
    t_coarse();
    t_fine();
    t_skip();
    t_single();
    t_idle();
    t_rewake();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule